// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block sits beside a memory controller and drives the one-time initialization of an SDRAM after power-up. On a start pulse it presents a fixed series of commands on a small command channel: one precharge-all, then a run of auto-refresh commands, then a mode-register write, and finally a command that puts the controller into normal operation. In that same update refresh is switched on. A done flag marks the end of the series and stays high until reset.

The command channel follows valid/ready rules. A command is presented with `cmd_valid_o` high and is taken on a clock edge where `cmd_ready_i` is also high. While the controller holds `cmd_ready_i` low, the block keeps both the command code and the valid strobe unchanged, so back-pressure of any length is allowed. After each accepted command, the strobe stays low for a parameter-set number of idle cycles before the next command is presented.

Once the series has finished, a two-stage refresh timer runs. A prescaler divides the clock by `prescale_i + 1`, and a counter of those ticks raises a one-cycle `refresh_req_o` pulse every `period_i + 1` ticks. The mode-register value is a constant parameter and is passed straight through to the output.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held, `cmd_valid_o`, `init_done_o`, `refresh_en_o` and `refresh_req_o` are 0, and `cmd_code_o` shows 0 (normal operation).
- R2: A start pulse sampled in the idle state makes `cmd_valid_o` rise on the next cycle, with `cmd_code_o` = 1 (precharge all banks) as the first command.
- R3: After the precharge, exactly NUM_AR (default 8) commands with code 2 (auto refresh) follow, one after the other.
- R4: After the last auto refresh comes one command with code 3 (mode register write), and after it one final command with code 0 (normal operation).
- R5: `refresh_en_o` is 0 for every earlier command. It rises in the first cycle the code-0 command is presented and then stays high.
- R6: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_code_o` does not change. Each accepted handshake moves the series on by exactly one command.
- R7: Between the acceptance of one command and the presentation of the next, `cmd_valid_o` is low for exactly GAP_CYCLES cycles.
- R8: `init_done_o` rises in the cycle after the code-0 command is accepted and stays high until reset.
- R9: A start pulse that arrives while the series is running, or after it has finished, has no effect. The series still has 1 + NUM_AR + 2 commands in total, and after done no command is presented.
- R10: With done high, `refresh_req_o` pulses for one cycle at (period_i+1)*(prescale_i+1) cycles after the first cycle of done, and then again every such interval.
- R11: `refresh_req_o` stays low until `init_done_o` is high.
- R12: `mode_word_o` always equals the MODE_WORD parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for the power-up series |
| cmd_ready_i | input | 1 | Controller accepts the presented command |
| prescale_i | input | PRE_W | Prescaler reload; tick every prescale_i+1 cycles |
| period_i | input | CNT_W | Refresh counter reload; request every period_i+1 ticks |
| cmd_valid_o | output | 1 | Command presented |
| cmd_code_o | output | 3 | Command code: 0 normal, 1 precharge all, 2 auto refresh, 3 mode write |
| refresh_en_o | output | 1 | Refresh enabled in the controller |
| init_done_o | output | 1 | Series finished, sticky until reset |
| refresh_req_o | output | 1 | One-cycle refresh request |
| mode_word_o | output | MODE_W | Constant mode-register value |

## Verification
The bench builds the block with NUM_AR at 8 and GAP_CYCLES at 2, so every idle gap and every auto-refresh count can be checked exactly. It sweeps prescale_i and period_i over all pairs from 0 to 3, which gives refresh intervals of 1 to 16 cycles, including the case where a request fires every cycle. Each sweep point uses a different back-pressure length of 0 to 2 cycles and injects stray start pulses during a gap and after done.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;
  typedef enum logic [2:0] {
    CMD_NORM = 3'd0,
    CMD_PREA = 3'd1,
    CMD_CBRR = 3'd2,
    CMD_MRW  = 3'd3
  } seq_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_GAP,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sps_gap_timer.sv
module sps_gap_timer #(
  parameter int GAP_CYCLES = 4,
  localparam int W = $clog2(GAP_CYCLES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= W'(GAP_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == W'(1));

  // R7: a loaded gap counts down one step per cycle
  assert_gap_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sps_seq_ctrl.sv
module sps_seq_ctrl
  import sdram_pwrup_pkg::*;
#(
  parameter int NUM_AR     = 8,
  parameter int GAP_CYCLES = 4,
  localparam int NSTEP     = NUM_AR + 3,
  localparam int STEP_W    = $clog2(NSTEP + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cmd_ready_i,
  input  logic       gap_last_i,
  output logic       gap_load_o,
  output logic       cmd_valid_o,
  output seq_cmd_e   cmd_code_o,
  output logic       refresh_en_o,
  output logic       done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);
  localparam logic [STEP_W-1:0] MRW_STEP  = STEP_W'(NUM_AR + 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  seq_cmd_e          step_cmd;
  logic              accept;

  assign accept = (state_q == ST_ISSUE) && cmd_ready_i;

  always_comb begin
    if (step_q == '0)            step_cmd = CMD_PREA;
    else if (step_q < MRW_STEP)  step_cmd = CMD_CBRR;
    else if (step_q == MRW_STEP) step_cmd = CMD_MRW;
    else                         step_cmd = CMD_NORM;
  end

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    gap_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ISSUE;
          step_d  = '0;
        end
      end
      ST_ISSUE: begin
        if (cmd_ready_i) begin
          if (step_q == LAST_STEP) begin
            state_d = ST_DONE;
          end else begin
            step_d = step_q + 1'b1;
            if (GAP_CYCLES == 0) begin
              state_d = ST_ISSUE;
            end else begin
              state_d    = ST_GAP;
              gap_load_o = 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        if (gap_last_i) state_d = ST_ISSUE;
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign cmd_valid_o  = (state_q == ST_ISSUE);
  assign cmd_code_o   = cmd_valid_o ? step_cmd : CMD_NORM;
  assign refresh_en_o = ((state_q == ST_ISSUE) && (step_q == LAST_STEP)) ||
                        (state_q == ST_DONE);
  assign done_o       = (state_q == ST_DONE);

  // R6: a stalled command keeps its strobe and its code
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_code_o)));

  // R7: an accepted non-final command is followed by an idle cycle
  assert_gap_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (GAP_CYCLES > 0 && accept && step_q != LAST_STEP) |=> !cmd_valid_o);

  // R5: the normal-operation command carries refresh enable
  assert_norm_with_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_code_o == CMD_NORM) |-> refresh_en_o);

  // R5: refresh enable never drops once raised
  assert_en_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en_o |=> refresh_en_o);

  // R8: done is sticky
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R9: nothing is presented once done
  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o);
endmodule

// File: rtl/sps_refresh_timer.sv
module sps_refresh_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             req_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      req_o <= 1'b0;
    end else if (!en_i) begin
      pre_q <= prescale_i;
      cnt_q <= period_i;
      req_o <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (tick) begin
        pre_q <= prescale_i;
        if (cnt_q == '0) begin
          cnt_q <= period_i;
          req_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  // R11: no request unless the timer was running
  assert_req_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(en_i));

  // R10: a request follows a prescaler tick with the counter at zero
  assert_req_on_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick && cnt_q == '0) |=> req_o);
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int              NUM_AR     = 8,
  parameter int              GAP_CYCLES = 4,
  parameter int              PRE_W      = 8,
  parameter int              CNT_W      = 8,
  parameter int              MODE_W     = 16,
  parameter logic [MODE_W-1:0] MODE_WORD = 16'h0032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmd_ready_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [CNT_W-1:0]  period_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_code_o,
  output logic              refresh_en_o,
  output logic              init_done_o,
  output logic              refresh_req_o,
  output logic [MODE_W-1:0] mode_word_o
);
  logic     gap_load, gap_last;
  seq_cmd_e code;

  sps_seq_ctrl #(.NUM_AR(NUM_AR), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_ready_i (cmd_ready_i),
    .gap_last_i  (gap_last),
    .gap_load_o  (gap_load),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (code),
    .refresh_en_o(refresh_en_o),
    .done_o      (init_done_o)
  );

  sps_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(gap_load),
    .last_o(gap_last)
  );

  sps_refresh_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_rfsh (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (init_done_o),
    .prescale_i(prescale_i),
    .period_i  (period_i),
    .req_o     (refresh_req_o)
  );

  assign cmd_code_o  = code;
  assign mode_word_o = MODE_WORD;
endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_NUM_AR  = 8;
  localparam int TB_GAP     = 2;
  localparam int NSTEP      = TB_NUM_AR + 3;
  localparam logic [15:0] TB_MODE = 16'h0032;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       cmd_ready_i = 1'b0;
  logic [7:0] prescale_i = '0;
  logic [7:0] period_i = '0;
  logic       cmd_valid_o, refresh_en_o, init_done_o, refresh_req_o;
  logic [2:0] cmd_code_o;
  logic [15:0] mode_word_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_pwrup_seq #(.NUM_AR(TB_NUM_AR), .GAP_CYCLES(TB_GAP),
                    .PRE_W(8), .CNT_W(8), .MODE_W(16), .MODE_WORD(TB_MODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_ready_i(cmd_ready_i),
    .prescale_i(prescale_i), .period_i(period_i),
    .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .refresh_en_o(refresh_en_o), .init_done_o(init_done_o),
    .refresh_req_o(refresh_req_o), .mode_word_o(mode_word_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input int i);
    if (i == 0) return 1;
    if (i <= TB_NUM_AR) return 2;
    if (i == TB_NUM_AR + 1) return 3;
    return 0;
  endfunction

  task automatic run_cfg(input int p, input int r, input int lat);
    int n, stall_bad, early_req, hits, stray, busy_bad, t;
    prescale_i = 8'(p);
    period_i   = 8'(r);
    rst_n = 1'b0; start_i = 1'b0; cmd_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !init_done_o && !refresh_en_o && !refresh_req_o && cmd_code_o == 3'd0,
        "R1 reset outputs", int'({cmd_valid_o, init_done_o, refresh_en_o, refresh_req_o, cmd_code_o}), 0);
    chk(mode_word_o == TB_MODE, "R12 mode word", int'(mode_word_o), int'(TB_MODE));
    rst_n = 1'b1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    stall_bad = 0; early_req = 0;
    for (int i = 0; i < NSTEP; i++) begin
      if (i == 0)
        chk(cmd_valid_o && cmd_code_o == 3'd1, "R2 first command precharge", int'(cmd_code_o), 1);
      else if (i <= TB_NUM_AR)
        chk(cmd_valid_o && int'(cmd_code_o) == 2, "R3 auto refresh command", int'(cmd_code_o), 2);
      else
        chk(cmd_valid_o && int'(cmd_code_o) == exp_code(i), "R4 mode write then normal", int'(cmd_code_o), exp_code(i));
      chk(refresh_en_o == (i == NSTEP - 1), "R5 refresh enable timing", int'(refresh_en_o), int'(i == NSTEP - 1));
      if (refresh_req_o) early_req++;
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        if (!cmd_valid_o || int'(cmd_code_o) != exp_code(i)) stall_bad++;
      end
      cmd_ready_i = 1'b1;
      @(negedge clk);
      cmd_ready_i = 1'b0;
      if (i == NSTEP - 1) begin
        chk(init_done_o && !cmd_valid_o, "R8 done after final accept", int'(init_done_o), 1);
      end else begin
        n = 0;
        while (!cmd_valid_o && n < 20) begin
          if (refresh_req_o) early_req++;
          if (i == 4 && n == 0) start_i = 1'b1;
          n++;
          @(negedge clk);
          start_i = 1'b0;
        end
        chk(n == TB_GAP, "R7 idle gap length", n, TB_GAP);
      end
    end
    chk(stall_bad == 0, "R6 hold under back-pressure", stall_bad, 0);
    chk(early_req == 0, "R11 no request before done", early_req, 0);
    t = (r + 1) * (p + 1);
    hits = 0; stray = 0; busy_bad = 0;
    for (int off = 0; off <= 2 * t; off++) begin
      if (refresh_req_o) begin
        if (off == t || off == 2 * t) hits++;
        else stray++;
      end
      if (cmd_valid_o || !init_done_o) busy_bad++;
      if (off == 1) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(hits == 2 && stray == 0, "R10 refresh request spacing", hits * 100 + stray, 200);
    chk(busy_bad == 0, "R9 start ignored after done", busy_bad, 0);
    chk(init_done_o && refresh_en_o, "R8 done sticky", int'(init_done_o), 1);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        run_cfg(p, r, (p + r) % 3);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule